// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a single-port synchronous SRAM. Reads and writes can follow each other on consecutive clocks with no idle cycle on the data bus. A word is 36 bits wide, split into four lanes of nine bits (eight data bits and one parity bit). Every control input is sampled on a rising clock edge, and only when the active-low clock enable is low. An edge that arrives while the enable is high changes nothing, so the previous cycle is stretched.

On a load cycle the block captures an address and an operation. On a following advance cycle it steps a 2-bit burst counter and repeats the loaded operation at the next address of the burst. The burst order is linear or XOR-interleaved, picked by a static mode input. Every operation uses the data bus in the cycle after its address edge. Read data is registered on the next enabled edge. Write data is sampled on the second enabled edge after the address edge. A read issued right behind a write to the same word gets the new bytes through a forwarding path. The bidirectional bus is modelled as a write-data input, a read-data output and a drive-enable output. The drive enable follows an asynchronous output-enable input and is gated off automatically outside read data phases.

Top module: `zsr_sram`

## Requirements
- R1: When `clk_en_n` is high at a rising edge, that edge is ignored: no write happens, `rdata` and `rdata_drive` keep their values, and no burst or pipeline state moves.
- R2: A load cycle selects the block only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. A load with any other combination is a deselect: it neither reads nor writes, and it ends any burst.
- R3: A read loaded at enabled edge E places the addressed word on `rdata` at the next enabled edge, and `rdata` holds it until the next read data is registered. After reset `rdata` is zero.
- R4: A write loaded at enabled edge E (`burst_step`=0, `wr_n`=0) takes its data from `wdata` at the second enabled edge after E.
- R5: Lane i is `wdata`/`rdata` bits [9i+8:9i]. A write changes lane i only when `lane_wr_n[i]` is 0 at the load cycle. Lanes with `lane_wr_n[i]`=1 keep their previous contents.
- R6: An advance cycle (`burst_step`=1) after a selected load issues the next burst address. The two low address bits become (start + k) mod 4 when `order_xor`=0 and start XOR k when `order_xor`=1, for beat k. The upper address bits, the operation type and the lane mask of the load are kept, and `wr_n` and `lane_wr_n` are ignored.
- R7: An advance cycle after a deselect or after reset does nothing: no read, no write, no drive.
- R8: `rdata_drive` is 1 only when `drive_en_n` is 0 (sampled asynchronously) and the current cycle is a read data phase. It is 0 during write data phases, while deselected, in the cycle after a load that follows a deselect, and after reset.
- R9: A read of the word written by the immediately preceding write returns the newly written lanes merged with the unwritten lanes' old contents, with no idle cycle between them.
- R10: A burst that goes on past four beats keeps wrapping inside the same aligned group of four addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| clk_en_n | input | 1 | Active-low clock qualifier; high stretches the cycle |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| burst_step | input | 1 | 1 = advance the burst, 0 = load a new address |
| wr_n | input | 1 | Operation on a load: 0 = write, 1 = read |
| lane_wr_n | input | 4 | Per-lane active-low write mask, sampled on a load |
| order_xor | input | 1 | Burst order: 1 = interleaved (XOR), 0 = linear |
| drive_en_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W (8) | Word address, sampled on a load |
| wdata | input | 36 | Write data from the bus |
| rdata | output | 36 | Registered read data |
| rdata_drive | output | 1 | Bus drive enable for `rdata` |

## Verification
The bench covers a read issued right behind the write it depends on. A design without forwarding would return the stale word there, and one that forwards every lane would clobber the masked lanes. Stalls with `clk_en_n` high are placed in the middle of write data phases and read bursts. A design that lets such an edge through would commit garbage or step the burst early. Bursts run in both orders from starting offsets where linear and XOR orders differ, and one write burst runs past four beats, so a wrong order or a carry out of the two low bits puts data at the wrong address. The bench also advances after a deselect and loads with every non-selecting chip-select combination. A model that keeps a stale burst alive or decodes the selects loosely would then drive the bus or overwrite memory.

// File: rtl/zsr_pkg.sv
package zsr_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned WORD_W = LANES * LANE_W;
  localparam int unsigned BEAT_W = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;

  // Offset inside the aligned group for beat number cnt of a burst
  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] cnt,
    input logic              xor_order
  );
    return xor_order ? (start ^ cnt) : (start + cnt);
  endfunction

  // Three-input select decode
  function automatic logic chip_selected(
    input logic s1_n,
    input logic s2,
    input logic s3_n
  );
    return !s1_n && s2 && !s3_n;
  endfunction

endpackage

// File: rtl/zsr_cmd.sv
module zsr_cmd import zsr_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              burst_step,
  input  logic              wr_n,
  input  lane_t             lane_wr_n,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr,
  output logic              iss_vld,
  output logic              iss_wr,
  output logic [ADDR_W-1:0] iss_addr,
  output lane_t             iss_lanes
);

  logic              burst_on;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic              op_wr_q;
  lane_t             op_lanes_q;

  // Named events for the assertions
  logic              selected;
  logic              load_ev;
  logic              desel_ev;
  logic              step_ev;
  logic              idle_step_ev;
  logic [BEAT_W-1:0] next_cnt;

  assign selected     = chip_selected(sel1_n, sel2, sel3_n);
  assign load_ev      = en && !burst_step && selected;
  assign desel_ev     = en && !burst_step && !selected;
  assign step_ev      = en && burst_step && burst_on;
  assign idle_step_ev = en && burst_step && !burst_on;
  assign next_cnt     = cnt_q + BEAT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_on   <= 1'b0;
      base_q     <= '0;
      cnt_q      <= '0;
      op_wr_q    <= 1'b0;
      op_lanes_q <= '1;
      iss_vld    <= 1'b0;
      iss_wr     <= 1'b0;
      iss_addr   <= '0;
      iss_lanes  <= '1;
    end else if (load_ev) begin
      burst_on   <= 1'b1;
      base_q     <= addr;
      cnt_q      <= '0;
      op_wr_q    <= !wr_n;
      op_lanes_q <= lane_wr_n;
      iss_vld    <= 1'b1;
      iss_wr     <= !wr_n;
      iss_addr   <= addr;
      iss_lanes  <= lane_wr_n;
    end else if (desel_ev) begin
      burst_on <= 1'b0;
      iss_vld  <= 1'b0;
    end else if (step_ev) begin
      cnt_q     <= next_cnt;
      iss_vld   <= 1'b1;
      iss_wr    <= op_wr_q;
      iss_lanes <= op_lanes_q;
      iss_addr  <= {base_q[ADDR_W-1:BEAT_W],
                    beat_offset(base_q[BEAT_W-1:0], next_cnt, order_xor)};
    end else if (idle_step_ev) begin
      iss_vld <= 1'b0;
    end
  end

  // R1: a masked edge moves no issue state
  assert_stall_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(iss_vld) && $stable(iss_addr) && $stable(iss_wr)));

  // R2: a load without a full select issues nothing
  assert_desel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !burst_step && !selected) |=> !iss_vld);

  // R7: an advance with no live burst issues nothing
  assert_idle_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && burst_step && !burst_on) |=> !iss_vld);

  // R6: linear order steps the low bits by one and keeps the upper bits
  assert_lin_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !order_xor) |=>
      ((iss_addr[BEAT_W-1:0] == $past(iss_addr[BEAT_W-1:0]) + BEAT_W'(1)) &&
       (iss_addr[ADDR_W-1:BEAT_W] == $past(iss_addr[ADDR_W-1:BEAT_W]))));

endmodule

// File: rtl/zsr_store.sv
module zsr_store import zsr_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              iss_vld,
  input  logic              iss_wr,
  input  logic [ADDR_W-1:0] iss_addr,
  input  lane_t             iss_lanes,
  input  word_t             wdata,
  output word_t             rdata_q,
  output logic              rd_phase,
  output logic              wr_phase
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] wb_addr;
  lane_t             wb_lanes;

  logic  commit;
  logic  rd_issue;
  logic  bypass_hit;
  word_t rd_word;

  assign commit     = en && wr_phase;
  assign rd_issue   = iss_vld && !iss_wr;
  assign bypass_hit = rd_issue && wr_phase && (wb_addr == iss_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_phase <= 1'b0;
      wb_addr  <= '0;
      wb_lanes <= '1;
      rd_phase <= 1'b0;
      rdata_q  <= '0;
    end else if (en) begin
      wr_phase <= iss_vld && iss_wr;
      wb_addr  <= iss_addr;
      wb_lanes <= iss_lanes;
      rd_phase <= rd_issue;
      if (rd_issue) rdata_q <= rd_word;
    end
  end

  // One storage array per lane; each lane has its own write strobe and
  // its own forwarding select
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] wr_bits;

    assign wr_bits = wdata[l*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (commit && !wb_lanes[l]) cells[wb_addr] <= wr_bits;
    end

    assign rd_word[l*LANE_W +: LANE_W] =
      (bypass_hit && !wb_lanes[l]) ? wr_bits : cells[iss_addr];
  end

  // R1: a masked edge leaves the data path untouched
  assert_stall_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(rdata_q) && $stable(rd_phase) && $stable(wr_phase)));

  // R9: a full-word write forwarded to the next read appears unchanged
  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bypass_hit && (wb_lanes == '0)) |=> (rdata_q == $past(wdata)));

endmodule

// File: rtl/zsr_sram.sv
module zsr_sram import zsr_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              burst_step,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              order_xor,
  input  logic              drive_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              rdata_drive
);

  logic              en;
  logic              iss_vld;
  logic              iss_wr;
  logic [ADDR_W-1:0] iss_addr;
  lane_t             iss_lanes;
  logic              rd_phase;
  logic              wr_phase;

  assign en = !clk_en_n;

  zsr_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .sel1_n     (sel1_n),
    .sel2       (sel2),
    .sel3_n     (sel3_n),
    .burst_step (burst_step),
    .wr_n       (wr_n),
    .lane_wr_n  (lane_wr_n),
    .order_xor  (order_xor),
    .addr       (addr),
    .iss_vld    (iss_vld),
    .iss_wr     (iss_wr),
    .iss_addr   (iss_addr),
    .iss_lanes  (iss_lanes)
  );

  zsr_store #(.ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .iss_vld   (iss_vld),
    .iss_wr    (iss_wr),
    .iss_addr  (iss_addr),
    .iss_lanes (iss_lanes),
    .wdata     (wdata),
    .rdata_q   (rdata),
    .rd_phase  (rd_phase),
    .wr_phase  (wr_phase)
  );

  // Drive only in a read data phase and only with the output enable low
  assign rdata_drive = !drive_en_n && rd_phase;

  // R8: the bus is never driven while write data is expected on it
  assert_no_drive_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |-> !rdata_drive);

  // R3: a read issued at an enabled edge opens a read data phase at the next one
  assert_read_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && iss_vld && !iss_wr) |=> rd_phase);

endmodule

// File: tb/sim_zsr_sram.sv
`timescale 1ns/1ps
module sim_zsr_sram;

  localparam logic [2:0] GOOD = 3'b010;
  localparam logic [2:0] IDLE = 3'b110;

  typedef struct packed {
    logic        cke_n;
    logic [2:0]  ce;
    logic        step;
    logic        wr_n;
    logic [3:0]  lanes;
    logic [7:0]  addr;
    logic [35:0] din;
    logic        exp_drive;
    logic [35:0] exp_data;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, GOOD, 1'b0, 1'b0, 4'b0000, 8'h10, 36'h0,           1'b0, 36'h0},
    '{1'b0, GOOD, 1'b0, 1'b0, 4'b0000, 8'h11, 36'h0,           1'b0, 36'h0},
    '{1'b0, GOOD, 1'b0, 1'b1, 4'b1111, 8'h10, 36'h1_2345_6789, 1'b0, 36'h0},
    '{1'b0, GOOD, 1'b0, 1'b1, 4'b1111, 8'h11, 36'h9_8765_4321, 1'b1, 36'h1_2345_6789},
    '{1'b1, GOOD, 1'b0, 1'b0, 4'b0000, 8'h10, 36'h0_0000_0BAD, 1'b1, 36'h1_2345_6789},
    '{1'b0, IDLE, 1'b0, 1'b1, 4'b1111, 8'h00, 36'h0,           1'b1, 36'h9_8765_4321},
    '{1'b0, GOOD, 1'b0, 1'b0, 4'b1010, 8'h10, 36'h0,           1'b0, 36'h0},
    '{1'b0, GOOD, 1'b0, 1'b1, 4'b1111, 8'h10, 36'h0,           1'b0, 36'h0},
    '{1'b0, GOOD, 1'b0, 1'b1, 4'b1111, 8'h10, 36'hF_FFFF_FFFF, 1'b1, 36'h1_27FD_67FF},
    '{1'b0, IDLE, 1'b0, 1'b1, 4'b1111, 8'h00, 36'h0,           1'b1, 36'h1_27FD_67FF},
    '{1'b0, IDLE, 1'b0, 1'b1, 4'b1111, 8'h00, 36'h0,           1'b0, 36'h0}
  };

  logic        clk;
  logic        rst_n;
  logic        clk_en_n;
  logic        sel1_n;
  logic        sel2;
  logic        sel3_n;
  logic        burst_step;
  logic        wr_n;
  logic [3:0]  lane_wr_n;
  logic        order_xor;
  logic        drive_en_n;
  logic [7:0]  addr;
  logic [35:0] wdata;
  logic [35:0] rdata;
  logic        rdata_drive;

  int          n_chk;
  int          n_fail;
  logic        done;
  logic [35:0] ref_mem [256];

  zsr_sram u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_en_n    (clk_en_n),
    .sel1_n      (sel1_n),
    .sel2        (sel2),
    .sel3_n      (sel3_n),
    .burst_step  (burst_step),
    .wr_n        (wr_n),
    .lane_wr_n   (lane_wr_n),
    .order_xor   (order_xor),
    .drive_en_n  (drive_en_n),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .rdata_drive (rdata_drive)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [35:0] pat(input logic [7:0] a);
    return {4'h5, a, ~a, a ^ 8'hC3, a + 8'h11};
  endfunction

  function automatic logic [7:0] lin_addr(input logic [7:0] s, input int k);
    logic [1:0] lo;
    lo = s[1:0] + 2'(k);
    return {s[7:2], lo};
  endfunction

  function automatic logic [7:0] xor_addr(input logic [7:0] s, input int k);
    return {s[7:2], s[1:0] ^ 2'(k)};
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, pass the rising edge, return at the next falling edge
  task automatic cyc(input logic ck, input logic [2:0] ce, input logic st,
                     input logic w, input logic [3:0] ln, input logic [7:0] a,
                     input logic [35:0] d);
    clk_en_n   = ck;
    sel1_n     = ce[2];
    sel2       = ce[1];
    sel3_n     = ce[0];
    burst_step = st;
    wr_n       = w;
    lane_wr_n  = ln;
    addr       = a;
    wdata      = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b0, IDLE, 1'b0, 1'b1, 4'hF, 8'h00, 36'h0);
  endtask

  initial begin
    done = 1'b0;
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk      = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    clk_en_n   = 1'b0;
    sel1_n     = 1'b1;
    sel2       = 1'b1;
    sel3_n     = 1'b0;
    burst_step = 1'b0;
    wr_n       = 1'b1;
    lane_wr_n  = 4'hF;
    order_xor  = 1'b0;
    drive_en_n = 1'b0;
    addr       = 8'h00;
    wdata      = 36'h0;
    repeat (3) @(negedge clk);
    check("R8 reset drive", {35'h0, rdata_drive}, 36'h0);
    check("R3 reset data", rdata, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: back-to-back writes and reads, a stall, a partial write, forwarding
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].cke_n, VEC[i].ce, VEC[i].step, VEC[i].wr_n, VEC[i].lanes,
          VEC[i].addr, VEC[i].din);
      check($sformatf("R1/R3/R4/R8 row %0d drive", i), {35'h0, rdata_drive},
            {35'h0, VEC[i].exp_drive});
      if (VEC[i].exp_drive)
        check($sformatf("R3/R4/R5/R9 row %0d data", i), rdata, VEC[i].exp_data);
    end
    ref_mem[8'h10] = 36'h1_27FD_67FF;
    ref_mem[8'h11] = 36'h9_8765_4321;

    // R10 / R6: six-beat linear write burst from 0x22, advances carry junk controls
    order_xor = 1'b0;
    for (int c = 0; c < 8; c++) begin
      logic [35:0] d;
      d = (c >= 2) ? pat(lin_addr(8'h22, c - 2)) + 36'(c - 2) : 36'h0;
      if (c == 0)     cyc(1'b0, GOOD, 1'b0, 1'b0, 4'h0, 8'h22, d);
      else if (c < 6) cyc(1'b0, GOOD, 1'b1, 1'b1, 4'hF, 8'h00, d);
      else            cyc(1'b0, IDLE, 1'b0, 1'b1, 4'hF, 8'h00, d);
      if (c >= 2) ref_mem[lin_addr(8'h22, c - 2)] = d;
      check("R8 write burst drive", {35'h0, rdata_drive}, 36'h0);
    end

    // R6: interleaved read burst from 0x21 (0x21, 0x20, 0x23, 0x22)
    order_xor = 1'b1;
    for (int c = 0; c < 6; c++) begin
      if (c == 0)     cyc(1'b0, GOOD, 1'b0, 1'b1, 4'hF, 8'h21, 36'h0);
      else if (c < 4) cyc(1'b0, GOOD, 1'b1, 1'b1, 4'hF, 8'h00, 36'h0);
      else            idle();
      if (c == 0) check("R8 first cycle after deselect", {35'h0, rdata_drive}, 36'h0);
      else if (c <= 4) begin
        check("R6 xor burst drive", {35'h0, rdata_drive}, 36'h1);
        check("R6 R10 xor burst data", rdata, ref_mem[xor_addr(8'h21, c - 1)]);
      end else check("R8 after burst", {35'h0, rdata_drive}, 36'h0);
    end
    order_xor = 1'b0;

    // R6 / R1: linear read burst from 0x23 with a stall in the middle
    cyc(1'b0, GOOD, 1'b0, 1'b1, 4'hF, 8'h23, 36'h0);
    check("R8 load after idle", {35'h0, rdata_drive}, 36'h0);
    cyc(1'b0, GOOD, 1'b1, 1'b1, 4'hF, 8'h00, 36'h0);
    check("R6 linear beat0", rdata, ref_mem[8'h23]);
    cyc(1'b1, GOOD, 1'b1, 1'b1, 4'hF, 8'h00, 36'h0);
    check("R1 stall holds data", rdata, ref_mem[8'h23]);
    check("R1 stall holds drive", {35'h0, rdata_drive}, 36'h1);
    cyc(1'b0, GOOD, 1'b1, 1'b1, 4'hF, 8'h00, 36'h0);
    check("R6 R10 linear wrap beat1", rdata, ref_mem[8'h20]);
    cyc(1'b0, GOOD, 1'b1, 1'b1, 4'hF, 8'h00, 36'h0);
    check("R6 linear beat2", rdata, ref_mem[8'h21]);
    idle();
    check("R6 linear beat3", rdata, ref_mem[8'h22]);
    idle();
    check("R8 deselected drive", {35'h0, rdata_drive}, 36'h0);

    // R7: advances after a deselect must not revive the read burst
    cyc(1'b0, GOOD, 1'b0, 1'b1, 4'hF, 8'h20, 36'h0);
    idle();
    check("R7 single read data", rdata, ref_mem[8'h20]);
    cyc(1'b0, GOOD, 1'b1, 1'b1, 4'hF, 8'h00, 36'h0);
    check("R7 deselect phase", {35'h0, rdata_drive}, 36'h0);
    cyc(1'b0, GOOD, 1'b1, 1'b1, 4'hF, 8'h00, 36'h0);
    check("R7 advance after deselect", {35'h0, rdata_drive}, 36'h0);
    idle();
    check("R7 second advance after deselect", {35'h0, rdata_drive}, 36'h0);

    // R2: every non-selecting chip-select combination, write then read
    for (int s = 0; s < 8; s++) begin
      if (s != 2) begin
        cyc(1'b0, 3'(s), 1'b0, 1'b0, 4'h0, 8'h20, 36'h0);
        check($sformatf("R2 select %0d write load", s), {35'h0, rdata_drive}, 36'h0);
        cyc(1'b0, 3'(s), 1'b0, 1'b1, 4'hF, 8'h20, 36'h0_0000_0BAD);
        check($sformatf("R2 select %0d phase", s), {35'h0, rdata_drive}, 36'h0);
        cyc(1'b0, IDLE, 1'b0, 1'b1, 4'hF, 8'h00, 36'h0_DEAD_BEEF);
        check($sformatf("R2 select %0d read", s), {35'h0, rdata_drive}, 36'h0);
      end
    end
    cyc(1'b0, GOOD, 1'b0, 1'b1, 4'hF, 8'h20, 36'h0);
    idle();
    check("R2 memory untouched", rdata, ref_mem[8'h20]);
    idle();

    // R8: the output enable gates the drive asynchronously
    drive_en_n = 1'b1;
    cyc(1'b0, GOOD, 1'b0, 1'b1, 4'hF, 8'h21, 36'h0);
    idle();
    check("R8 enable high blocks drive", {35'h0, rdata_drive}, 36'h0);
    check("R3 data with enable high", rdata, ref_mem[8'h21]);
    drive_en_n = 1'b0;
    #1;
    check("R8 enable low drives", {35'h0, rdata_drive}, 36'h1);
    idle();
    check("R8 drive ends", {35'h0, rdata_drive}, 36'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule